// File: doc/BRIEF.md
# ChaCha Keystream Block Engine

This engine produces 512-bit ChaCha keystream blocks and XORs each one with a 512-bit data word. An `init_i` pulse stores the key, its length, the nonce and a starting block count. It then generates the first block. Each later `next_i` pulse generates the following block. The engine reuses the stored key and nonce, and its own 64-bit block counter has stepped by one since the previous block. Each round updates the whole state in one cycle, because four quarter-round lanes run in parallel. Even-numbered rounds work on the columns and odd-numbered rounds on the diagonals. The round count is read again with every accepted pulse, so it can change from block to block.

A small state machine drives the block. **IDLE** waits with `ready_o` high. An accepted pulse (IDLE→LOAD) captures the inputs and clears `valid_o`. **LOAD** builds the sixteen-word initial state and copies it into the working state (LOAD→ROUND). **ROUND** applies one round per cycle. It moves on to FINAL after the last round (ROUND→FINAL) and stays in ROUND otherwise (ROUND→ROUND). **FINAL** adds the initial state to the working state word by word. It serializes the result, XORs it with the captured data, registers it on `data_o`, raises `valid_o`, steps the counter and returns to IDLE (FINAL→IDLE). IDLE stays in IDLE when no pulse arrives.

Top module: `chacha_ks_core`

## Requirements
- R1: While reset is held and just after it is released, `ready_o` is 1, `valid_o` is 0 and `data_o` is all zero.
- R2: A pulse is accepted at a clock edge where `ready_o` is 1. `ready_o` then stays low for N+2 cycles, where N is the number of rounds. The result appears together with `ready_o` high, N+3 cycles after the cycle in which the pulse was applied. With 8 rounds this is 11 cycles.
- R3: `rounds_sel_i` = s selects 2·(s+1) rounds, which covers 2 to 32 in steps of two. The value 3 gives the usual 8 rounds and 15 gives 32 rounds.
- R4: With `key_long_i`=1, state words 0–3 hold the ASCII text "expand 32-byte k", read little-endian. Words 4–11 hold the 32 key bytes. Key byte 0 is `key_i[255:248]`, and each word is assembled little-endian from four consecutive bytes. With an all-zero key, nonce and counter, 20 rounds and zero data, the first eight output bytes are 76 b8 e0 ad a0 f1 3d 90.
- R5: With `key_long_i`=0, the constant text is "expand 16-byte k". Only `key_i[255:128]` is used, and it fills words 4–7 and again words 8–11. `key_i[127:0]` has no effect on the output.
- R6: Word 12 is the counter bits 31:0 and word 13 is bits 63:32. Words 14–15 hold the nonce bytes, where nonce byte 0 is `nonce_i[63:56]`, packed little-endian. `init_i` loads the counter from `ctr_i`.
- R7: Every finished block steps the internal counter by one, modulo 2^64. `next_i` uses the stored key, key length and nonce with the stepped counter.
- R8: `data_o` equals the keystream XOR the `data_i` value captured at the accepting edge. Byte j of the keystream stands at `data_o[511-8j -: 8]`. Word w contributes bytes 4w..4w+3, least significant byte first.
- R9: `init_i` or `next_i` pulses that arrive while `ready_o` is 0 are ignored. The result, its timing and the counter are unchanged.
- R10: `valid_o` goes low at the accepting edge and rises together with `ready_o` when the result is written. `data_o` changes only at that edge and holds its value otherwise.
- R11: When `init_i` and `next_i` are both high at an accepting edge, the `init_i` behaviour applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load key, nonce and counter, then generate a block |
| next_i | input | 1 | Generate the next block with the stepped counter |
| key_i | input | 256 | Key bytes, byte 0 in the top bits |
| key_long_i | input | 1 | 1 = 256-bit key, 0 = 128-bit key in the upper half |
| nonce_i | input | 64 | Nonce bytes, byte 0 in the top bits |
| ctr_i | input | 64 | Starting block count, loaded by `init_i` |
| rounds_sel_i | input | RSEL_W (4) | Round selector, rounds = 2·(value+1) |
| data_i | input | 512 | Data to combine with the keystream |
| ready_o | output | 1 | High when idle and able to accept a pulse |
| data_o | output | 512 | Keystream XOR captured data |
| valid_o | output | 1 | High while `data_o` holds a finished block |

## Verification
On every cycle, the assertions check the port handshake. An accepted pulse drops both `ready_o` and `valid_o`. `data_o` moves only on the edge that raises `valid_o` with `ready_o`. The busy period always lasts the number of rounds plus two, counted from the round selector captured at acceptance. The keystream content itself can only be confirmed by the bench scenarios, which compare against a behavioural model. These scenarios cover the known all-zero vector, the 128-bit key layout, the counter wrap, the blocking of pulses that arrive while busy, and init taking priority over next.

// File: rtl/chacha_ks_pkg.sv
`timescale 1ns/100ps
package chacha_ks_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 16;
    localparam int LANES   = N_WORDS / 4;
    localparam int KEY_W   = 256;
    localparam int NONCE_W = 64;
    localparam int CTR_W   = 64;
    localparam int BLK_W   = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [N_WORDS-1:0] state_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ROUND = 2'd2,
        ST_FINAL = 2'd3
    } ks_state_e;

    function automatic word_t bswap(word_t w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // constant words: ASCII text read little-endian
    function automatic word_t const_word(int i, logic long_key);
        case (i)
            0:       return 32'h6170_7865;
            1:       return long_key ? 32'h3320_646e : 32'h3120_646e;
            2:       return long_key ? 32'h7962_2d32 : 32'h7962_2d36;
            default: return 32'h6b20_6574;
        endcase
    endfunction

    // state index of row 'row' in lane 'lane'; diagonal mode shifts each row
    function automatic int qr_idx(int lane, int row, logic diag);
        return row * 4 + (diag ? ((lane + row) % 4) : lane);
    endfunction
endpackage

// File: rtl/chacha_ks_qr.sv
`timescale 1ns/100ps
module chacha_ks_qr
    import chacha_ks_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);
    word_t a1, c1, d1, b1, a2, c2, d2, b2;
    word_t dx1, bx1, dx2, bx2;

    assign a1  = a_i + b_i;
    assign dx1 = d_i ^ a1;
    assign d1  = {dx1[15:0], dx1[31:16]};
    assign c1  = c_i + d1;
    assign bx1 = b_i ^ c1;
    assign b1  = {bx1[19:0], bx1[31:20]};
    assign a2  = a1 + b1;
    assign dx2 = d1 ^ a2;
    assign d2  = {dx2[23:0], dx2[31:24]};
    assign c2  = c1 + d2;
    assign bx2 = b1 ^ c2;
    assign b2  = {bx2[24:0], bx2[31:25]};

    assign a_o = a2;
    assign b_o = b2;
    assign c_o = c2;
    assign d_o = d2;
endmodule

// File: rtl/chacha_ks_round.sv
`timescale 1ns/100ps
module chacha_ks_round
    import chacha_ks_pkg::*;
(
    input  state_t st_i,
    input  logic   diag_i,
    output state_t st_o
);
    word_t lane_in  [LANES][4];
    word_t lane_out [LANES][4];

    always_comb begin
        for (int l = 0; l < LANES; l++)
            for (int r = 0; r < 4; r++)
                lane_in[l][r] = st_i[qr_idx(l, r, diag_i)];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        chacha_ks_qr u_qr (
            .a_i(lane_in[g][0]),  .b_i(lane_in[g][1]),
            .c_i(lane_in[g][2]),  .d_i(lane_in[g][3]),
            .a_o(lane_out[g][0]), .b_o(lane_out[g][1]),
            .c_o(lane_out[g][2]), .d_o(lane_out[g][3])
        );
    end

    always_comb begin
        st_o = st_i;
        for (int l = 0; l < LANES; l++)
            for (int r = 0; r < 4; r++)
                st_o[qr_idx(l, r, diag_i)] = lane_out[l][r];
    end
endmodule

// File: rtl/chacha_ks_init.sv
`timescale 1ns/100ps
module chacha_ks_init
    import chacha_ks_pkg::*;
(
    input  logic [KEY_W-1:0]   key_i,
    input  logic               long_i,
    input  logic [NONCE_W-1:0] nonce_i,
    input  logic [CTR_W-1:0]   ctr_i,
    output state_t             st_o
);
    localparam int KEY_WORDS = KEY_W / WORD_W;

    always_comb begin
        st_o = '0;
        for (int i = 0; i < 4; i++)
            st_o[i] = const_word(i, long_i);
        for (int i = 0; i < KEY_WORDS; i++) begin
            int src;
            src = long_i ? i : (i % (KEY_WORDS / 2));
            st_o[4 + i] = bswap(key_i[KEY_W-1-WORD_W*src -: WORD_W]);
        end
        st_o[12] = ctr_i[WORD_W-1:0];
        st_o[13] = ctr_i[CTR_W-1:WORD_W];
        st_o[14] = bswap(nonce_i[NONCE_W-1 -: WORD_W]);
        st_o[15] = bswap(nonce_i[WORD_W-1:0]);
    end
endmodule

// File: rtl/chacha_ks_core.sv
`timescale 1ns/100ps
module chacha_ks_core
    import chacha_ks_pkg::*;
#(
    parameter int RSEL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               next_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic               key_long_i,
    input  logic [NONCE_W-1:0] nonce_i,
    input  logic [CTR_W-1:0]   ctr_i,
    input  logic [RSEL_W-1:0]  rounds_sel_i,
    input  logic [BLK_W-1:0]   data_i,
    output logic               ready_o,
    output logic [BLK_W-1:0]   data_o,
    output logic               valid_o
);
    localparam int RCNT_W = RSEL_W + 1;

    ks_state_e            state_q, state_d;
    logic [KEY_W-1:0]     key_q;
    logic                 long_q;
    logic [NONCE_W-1:0]   nonce_q;
    logic [CTR_W-1:0]     ctr_q;
    logic [RSEL_W-1:0]    rsel_q;
    logic [RCNT_W-1:0]    rcnt_q;
    logic [BLK_W-1:0]     din_q;
    logic [BLK_W-1:0]     dout_q;
    logic                 valid_q;
    state_t               init_st_q, work_q;
    state_t               built_st, round_st;
    logic [BLK_W-1:0]     ks_flat;
    logic                 accept, last_round;

    assign accept     = (state_q == ST_IDLE) && (init_i || next_i);
    assign last_round = (rcnt_q == {rsel_q, 1'b1});

    chacha_ks_init u_init (
        .key_i(key_q), .long_i(long_q), .nonce_i(nonce_q),
        .ctr_i(ctr_q), .st_o(built_st)
    );

    chacha_ks_round u_round (
        .st_i(work_q), .diag_i(rcnt_q[0]), .st_o(round_st)
    );

    always_comb begin
        ks_flat = '0;
        for (int i = 0; i < N_WORDS; i++)
            ks_flat[BLK_W-1-WORD_W*i -: WORD_W] = bswap(work_q[i] + init_st_q[i]);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (init_i || next_i) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_ROUND;
            ST_ROUND: if (last_round) state_d = ST_FINAL;
            ST_FINAL: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q     <= '0;
            long_q    <= 1'b0;
            nonce_q   <= '0;
            ctr_q     <= '0;
            rsel_q    <= '0;
            rcnt_q    <= '0;
            din_q     <= '0;
            dout_q    <= '0;
            valid_q   <= 1'b0;
            init_st_q <= '0;
            work_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (init_i) begin
                            key_q   <= key_i;
                            long_q  <= key_long_i;
                            nonce_q <= nonce_i;
                            ctr_q   <= ctr_i;
                        end
                        rsel_q  <= rounds_sel_i;
                        din_q   <= data_i;
                        valid_q <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    init_st_q <= built_st;
                    work_q    <= built_st;
                    rcnt_q    <= '0;
                end
                ST_ROUND: begin
                    work_q <= round_st;
                    rcnt_q <= rcnt_q + 1'b1;
                end
                ST_FINAL: begin
                    dout_q  <= ks_flat ^ din_q;
                    valid_q <= 1'b1;
                    ctr_q   <= ctr_q + 1'b1;
                end
            endcase
        end
    end

    assign ready_o = (state_q == ST_IDLE);
    assign data_o  = dout_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/chacha_ks_chk.sv
`timescale 1ns/100ps
module chacha_ks_chk
    import chacha_ks_pkg::*;
#(
    parameter int RSEL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              next_i,
    input logic [RSEL_W-1:0] rounds_sel_i,
    input logic              ready_o,
    input logic              valid_o,
    input logic [BLK_W-1:0]  data_o
);
    localparam int CNT_W = RSEL_W + 3;

    logic [CNT_W-1:0]  busy_cnt;
    logic [RSEL_W-1:0] rsel_cap;
    logic [CNT_W-1:0]  exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            rsel_cap <= '0;
        end else if (ready_o && (init_i || next_i)) begin
            busy_cnt <= '0;
            rsel_cap <= rounds_sel_i;
        end else if (!ready_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assign exp_len = CNT_W'({rsel_cap, 1'b0}) + CNT_W'(4);

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && (init_i || next_i)) |=> !ready_o);

    // R10
    accept_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && (init_i || next_i)) |=> !valid_o);

    // R10
    output_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> (ready_o && valid_o && !$past(ready_o)));

    // R10
    valid_rises_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $rose(ready_o));

    // R3
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (busy_cnt == exp_len));
endmodule

bind chacha_ks_core chacha_ks_chk #(.RSEL_W(RSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
    .rounds_sel_i(rounds_sel_i), .ready_o(ready_o), .valid_o(valid_o),
    .data_o(data_o)
);

// File: tb/sim_chacha_ks_core.sv
`timescale 1ns/100ps
module sim_chacha_ks_core;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         init_p, next_p, key_long;
    logic [255:0] key;
    logic [63:0]  nonce, ctr;
    logic [3:0]   rsel;
    logic [511:0] din;
    logic         ready, valid;
    logic [511:0] dout;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    chacha_ks_core #(.RSEL_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .init_i(init_p), .next_i(next_p),
        .key_i(key), .key_long_i(key_long), .nonce_i(nonce), .ctr_i(ctr),
        .rounds_sel_i(rsel), .data_i(din), .ready_o(ready), .data_o(dout),
        .valid_o(valid)
    );

    function automatic logic [31:0] rotl(logic [31:0] v, int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic logic [127:0] qround(logic [31:0] a, logic [31:0] b,
                                            logic [31:0] c, logic [31:0] d);
        a = a + b; d = rotl(d ^ a, 16);
        c = c + d; b = rotl(b ^ c, 12);
        a = a + b; d = rotl(d ^ a, 8);
        c = c + d; b = rotl(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    function automatic logic [511:0] ref_block(logic [255:0] k, bit lng,
            logic [63:0] n, logic [63:0] c, int rounds, logic [511:0] d);
        logic [31:0]  x [16];
        logic [31:0]  s [16];
        logic [7:0]   kb [32];
        logic [127:0] cs;
        logic [511:0] res;
        int           ix [4];
        cs = lng ? "expand 32-byte k" : "expand 16-byte k";
        for (int j = 0; j < 32; j++)
            kb[j] = (lng || j < 16) ? k[255-8*j -: 8] : k[255-8*(j-16) -: 8];
        for (int w = 0; w < 4; w++)
            s[w] = {cs[127-8*(4*w+3) -: 8], cs[127-8*(4*w+2) -: 8],
                    cs[127-8*(4*w+1) -: 8], cs[127-8*(4*w) -: 8]};
        for (int w = 0; w < 8; w++)
            s[4+w] = {kb[4*w+3], kb[4*w+2], kb[4*w+1], kb[4*w]};
        s[12] = c[31:0];
        s[13] = c[63:32];
        s[14] = {n[39:32], n[47:40], n[55:48], n[63:56]};
        s[15] = {n[7:0], n[15:8], n[23:16], n[31:24]};
        for (int w = 0; w < 16; w++) x[w] = s[w];
        for (int r = 0; r < rounds; r++) begin
            for (int i = 0; i < 4; i++) begin
                logic [127:0] q;
                if (r % 2 == 0) begin
                    ix[0] = i; ix[1] = i + 4; ix[2] = i + 8; ix[3] = i + 12;
                end else begin
                    ix[0] = i; ix[1] = 4 + (i + 1) % 4;
                    ix[2] = 8 + (i + 2) % 4; ix[3] = 12 + (i + 3) % 4;
                end
                q = qround(x[ix[0]], x[ix[1]], x[ix[2]], x[ix[3]]);
                x[ix[0]] = q[127:96]; x[ix[1]] = q[95:64];
                x[ix[2]] = q[63:32];  x[ix[3]] = q[31:0];
            end
        end
        for (int w = 0; w < 16; w++) begin
            logic [31:0] v;
            v = x[w] + s[w];
            for (int m = 0; m < 4; m++)
                res[511-8*(4*w+m) -: 8] = v[8*m +: 8] ^ d[511-8*(4*w+m) -: 8];
        end
        return res;
    endfunction

    // cycle-level reference model
    logic [255:0] m_key;
    bit           m_long;
    logic [63:0]  m_nonce, m_ctr;
    logic [511:0] m_pend, exp_dout;
    bit           exp_ready, exp_valid;
    int           m_busy;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_key = '0; m_long = 0; m_nonce = '0; m_ctr = '0;
            m_pend = '0; exp_dout = '0; exp_ready = 1; exp_valid = 0; m_busy = 0;
        end else if (exp_ready && (init_p || next_p)) begin
            if (init_p) begin
                m_key = key; m_long = key_long; m_nonce = nonce; m_ctr = ctr;
            end
            m_pend = ref_block(m_key, m_long, m_nonce, m_ctr, 2 * (int'(rsel) + 1), din);
            m_busy = 2 * (int'(rsel) + 1) + 2;
            exp_ready = 0; exp_valid = 0;
        end else if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
                exp_ready = 1; exp_valid = 1; exp_dout = m_pend; m_ctr = m_ctr + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(ready == exp_ready, "R2 ready per cycle", 512'(ready), 512'(exp_ready));
            chk(valid == exp_valid, "R10 valid per cycle", 512'(valid), 512'(exp_valid));
            chk(dout == exp_dout, "R8 data per cycle", dout, exp_dout);
        end
    end

    task automatic start(bit i, bit n, logic [255:0] k, bit lng, logic [63:0] no,
                         logic [63:0] c, logic [3:0] rs, logic [511:0] d);
        @(negedge clk);
        init_p = i; next_p = n; key = k; key_long = lng; nonce = no;
        ctr = c; rsel = rs; din = d;
        @(negedge clk);
        init_p = 0; next_p = 0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        logic [511:0] e, first;
        logic [255:0] ka, kb2;
        rst_n = 0; init_p = 0; next_p = 0; key = '0; key_long = 0;
        nonce = '0; ctr = '0; rsel = '0; din = '0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1 ready in reset", 512'(ready), 512'(1));
        chk(valid == 1'b0, "R1 valid in reset", 512'(valid), 512'(0));
        chk(dout == '0, "R1 data in reset", dout, '0);
        rst_n = 1;
        @(negedge clk);
        chk(ready && !valid && dout == '0, "R1 after release", dout, '0);

        // R4 known all-zero vector, 20 rounds; R2 latency
        start(1, 0, '0, 1, '0, '0, 4'd9, '0);
        chk(!valid, "R10 valid low after accept", 512'(valid), 512'(0));
        wait_done(n);
        chk(n == 22, "R2 busy cycles for 20 rounds", 512'(n), 512'(22));
        chk(dout[511:448] == 64'h76b8e0ada0f13d90, "R4 known vector",
            512'(dout[511:448]), 512'(64'h76b8e0ada0f13d90));
        e = ref_block('0, 1, '0, 64'd0, 20, '0);
        chk(dout == e, "R4 full block", dout, e);

        // R7 next with stepped counter, R3 8 rounds, R8 data XOR
        start(0, 1, '1, 0, '1, '1, 4'd3, {16{32'hdead_beef}});
        wait_done(n);
        chk(n == 10, "R3 busy cycles for 8 rounds", 512'(n), 512'(10));
        e = ref_block('0, 1, '0, 64'd1, 8, {16{32'hdead_beef}});
        chk(dout == e, "R7 R8 next block", dout, e);

        // R5 R6 128-bit key, nonce and counter layout, 2 rounds
        start(1, 0, {128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 128'h1111}, 0,
              64'h0102030405060708, 64'h0123456789abcdef, 4'd0, {8{64'h5a5a_0000_ffff_1234}});
        wait_done(n);
        e = ref_block({128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 128'h0}, 0,
                      64'h0102030405060708, 64'h0123456789abcdef, 2, {8{64'h5a5a_0000_ffff_1234}});
        chk(dout == e, "R6 short key block", dout, e);
        first = dout;
        start(1, 0, {128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 128'hffff_9999_abcd}, 0,
              64'h0102030405060708, 64'h0123456789abcdef, 4'd0, {8{64'h5a5a_0000_ffff_1234}});
        wait_done(n);
        chk(dout == first, "R5 low key half no effect", dout, first);

        // R9 pulses while busy are ignored
        ka  = 256'h00112233_44556677_8899aabb_ccddeeff_01234567_89abcdef_fedcba98_76543210;
        kb2 = ~ka;
        start(1, 0, ka, 1, 64'hcafef00d_12345678, 64'd40, 4'd3, '0);
        repeat (3) @(negedge clk);
        init_p = 1; next_p = 1; key = kb2; ctr = 64'd900; rsel = 4'd0;
        @(negedge clk);
        init_p = 0; next_p = 0;
        wait_done(n);
        e = ref_block(ka, 1, 64'hcafef00d_12345678, 64'd40, 8, '0);
        chk(dout == e, "R9 busy pulse ignored", dout, e);
        start(0, 1, kb2, 1, '0, '0, 4'd3, '0);
        wait_done(n);
        e = ref_block(ka, 1, 64'hcafef00d_12345678, 64'd41, 8, '0);
        chk(dout == e, "R9 counter stepped once", dout, e);

        // R7 counter wrap
        start(1, 0, ka, 1, 64'h77, 64'hffff_ffff_ffff_ffff, 4'd1, '0);
        wait_done(n);
        e = ref_block(ka, 1, 64'h77, 64'hffff_ffff_ffff_ffff, 4, '0);
        chk(dout == e, "R7 last counter value", dout, e);
        start(0, 1, '0, 0, '0, '0, 4'd1, '0);
        wait_done(n);
        e = ref_block(ka, 1, 64'h77, 64'd0, 4, '0);
        chk(dout == e, "R7 counter wraps to zero", dout, e);

        // R11 init wins over next
        start(1, 1, kb2, 1, 64'h99, 64'd5, 4'd2, '1);
        wait_done(n);
        e = ref_block(kb2, 1, 64'h99, 64'd5, 6, '1);
        chk(dout == e, "R11 init priority", dout, e);

        // R3 32 rounds
        start(0, 1, '0, 0, '0, '0, 4'd15, '0);
        wait_done(n);
        chk(n == 34, "R3 busy cycles for 32 rounds", 512'(n), 512'(34));
        e = ref_block(kb2, 1, 64'h99, 64'd6, 32, '0);
        chk(dout == e, "R3 32 round block", dout, e);

        repeat (4) @(negedge clk);
        chk(valid && dout == e, "R10 output held while idle", dout, e);
        summary();
    end
endmodule